// File: doc/BRIEF.md
# SPI Flash Status Emulator

This block sits on the target side of a SPI link and behaves like the status and addressing logic of a serial NOR flash. The SPI pins are oversampled by the system clock. In each chip-select frame the block takes the first byte on MOSI as an opcode. A write-enable opcode sets the write-enable latch and a write-disable opcode clears it. Two further opcodes switch the address width between 3 and 4 bytes. Three read opcodes each return one byte of a 24-bit status word on MISO.

Firmware uses a register-side port to write a new status word. The word waits in a staging register and reaches the live status only at the next chip-select rising edge. This keeps the status seen by the host steady for the whole of a frame. The live status word and the address-mode flag are always readable on that port.

Top module: `spi_status_emu`

## Requirements
- R1: A frame holding exactly the opcode 0x06 sets status bit 1 (the write-enable latch). The change appears on `status_o` after chip select goes high.
- R2: A frame holding exactly the opcode 0x04 clears status bit 1.
- R3: A frame holding exactly 0xB7 sets `addr4b_o`, and a frame holding exactly 0xE9 clears it. `addr4b_o` changes only at the end of a frame.
- R4: After the eighth opcode bit, opcode 0x05 returns status[7:0], opcode 0x35 returns status[15:8] and opcode 0x15 returns status[23:16]. Each byte is sent MSB first. Bits are launched on the SCK falling edge and are valid for the next rising edge (SPI mode 0).
- R5: If the host keeps clocking during a status read, the selected byte is sent again.
- R6: A word written on `fw_wdata` with `fw_wr` high is not visible on `status_o` or over SPI until the next chip-select rising edge. After that edge it is visible on both.
- R7: A frame that ends with any bit count other than 8 changes neither the status nor the address mode.
- R8: An opcode with no meaning here is ignored, and MISO stays 0 for the rest of that frame.
- R9: A write-enable or write-disable frame that ends on the same edge as a staged-word copy wins over bit 1 of the staged word.
- R10: Reset clears the live status, the staging register and the address mode. MISO is 0 whenever chip select is high.
- R11: Status bit 0 (write in progress) changes only through a firmware write. No opcode alters it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | SPI serial clock from the host |
| csb | input | 1 | Active-low chip select from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| fw_wr | input | 1 | Strobe that loads `fw_wdata` into the staging register |
| fw_wdata | input | 24 | New status word from firmware |
| status_o | output | 24 | Live status word |
| addr4b_o | output | 1 | High while 4-byte address mode is active |

## Verification
The bench sends frames of 7 and 9 bits that carry an enable or mode opcode. A design that committed on any count of 8 or more, or on a partial byte, would then change the latch or the mode by mistake. It writes a status word from firmware and checks that the live value stays the same until a frame closes. A design that took the write at once would show it early. It sends write-enable and write-disable frames just after staged words whose bit 1 is the opposite value. A design that gave the staged copy priority would lose the latch change. It also reads each status byte through several repeats and checks MISO on an unknown opcode. This catches a wrong byte select, a wrong bit order, a missing wrap, or stray data on the line.

// File: rtl/spi_status_emu.sv
module spi_status_emu #(
  parameter int          SYNC       = 2,
  parameter int          SW         = 24,
  parameter logic [7:0]  OP_WREN    = 8'h06,
  parameter logic [7:0]  OP_WRDI    = 8'h04,
  parameter logic [7:0]  OP_RDSR0   = 8'h05,
  parameter logic [7:0]  OP_RDSR1   = 8'h35,
  parameter logic [7:0]  OP_RDSR2   = 8'h15,
  parameter logic [7:0]  OP_ADDR4   = 8'hB7,
  parameter logic [7:0]  OP_ADDR3   = 8'hE9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck,
  input  logic          csb,
  input  logic          mosi,
  output logic          miso,
  input  logic          fw_wr,
  input  logic [SW-1:0] fw_wdata,
  output logic [SW-1:0] status_o,
  output logic          addr4b_o
);
  localparam int WEL_BIT = 1;
  localparam int CNT_W   = 4;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [SYNC-1:0] sck_sy, csb_sy, mosi_sy;
  logic sck_q, csb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy  <= '0;
      csb_sy  <= '1;
      mosi_sy <= '0;
      sck_q   <= 1'b0;
      csb_q   <= 1'b1;
    end else begin
      sck_sy  <= {sck_sy[SYNC-2:0], sck};
      csb_sy  <= {csb_sy[SYNC-2:0], csb};
      mosi_sy <= {mosi_sy[SYNC-2:0], mosi};
      sck_q   <= sck_sy[SYNC-1];
      csb_q   <= csb_sy[SYNC-1];
    end
  end

  logic sck_s, csb_s, mosi_s;
  assign sck_s  = sck_sy[SYNC-1];
  assign csb_s  = csb_sy[SYNC-1];
  assign mosi_s = mosi_sy[SYNC-1];

  logic sck_rise, sck_fall, cs_rise, cs_fall, in_frame;
  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;
  assign cs_rise  = csb_s & ~csb_q;
  assign cs_fall  = ~csb_s & csb_q;
  assign in_frame = ~csb_s;

  logic [CNT_W-1:0] bit_cnt;
  logic [7:0]       opcode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      opcode  <= '0;
    end else if (cs_fall) begin
      bit_cnt <= '0;
      opcode  <= '0;
    end else if (in_frame && sck_rise) begin
      if (bit_cnt < CNT_W'(8)) opcode <= {opcode[6:0], mosi_s};
      if (bit_cnt != CNT_MAX)  bit_cnt <= bit_cnt + 1'b1;
    end
  end

  logic          out_active;
  logic [2:0]    out_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_active <= 1'b0;
      out_idx    <= 3'd7;
    end else if (cs_fall || cs_rise) begin
      out_active <= 1'b0;
      out_idx    <= 3'd7;
    end else if (in_frame && sck_fall && bit_cnt >= CNT_W'(8)) begin
      if (!out_active) begin
        out_active <= 1'b1;
        out_idx    <= 3'd7;
      end else begin
        out_idx    <= out_idx - 1'b1;
      end
    end
  end

  logic [SW-1:0] live, stage;
  logic          pending;
  logic          addr4b;

  logic [7:0] rd_byte;
  logic       rd_hit;
  always_comb begin
    rd_hit  = 1'b1;
    rd_byte = 8'h00;
    case (opcode)
      OP_RDSR0: rd_byte = live[7:0];
      OP_RDSR1: rd_byte = live[15:8];
      OP_RDSR2: rd_byte = live[23:16];
      default:  rd_hit  = 1'b0;
    endcase
  end

  assign miso = out_active & rd_hit & rd_byte[out_idx];

  logic exact8;
  assign exact8 = (bit_cnt == CNT_W'(8));

  logic [SW-1:0] live_nx;
  always_comb begin
    live_nx = pending ? stage : live;
    if (exact8 && opcode == OP_WREN) live_nx[WEL_BIT] = 1'b1;
    if (exact8 && opcode == OP_WRDI) live_nx[WEL_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live    <= '0;
      stage   <= '0;
      pending <= 1'b0;
      addr4b  <= 1'b0;
    end else begin
      if (cs_rise) begin
        live <= live_nx;
        if (exact8 && opcode == OP_ADDR4) addr4b <= 1'b1;
        if (exact8 && opcode == OP_ADDR3) addr4b <= 1'b0;
      end
      if (fw_wr) begin
        stage   <= fw_wdata;
        pending <= 1'b1;
      end else if (cs_rise) begin
        pending <= 1'b0;
      end
    end
  end

  assign status_o = live;
  assign addr4b_o = addr4b;
endmodule

// File: rtl/spi_status_emu_chk.sv
module spi_status_emu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        csb_s,
  input logic        cs_rise,
  input logic        pending,
  input logic [3:0]  bit_cnt,
  input logic        miso,
  input logic [23:0] status_o,
  input logic        addr4b_o
);
  // R6
  status_only_at_cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(status_o));

  // R3
  mode_only_at_cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(addr4b_o));

  // R7
  short_frame_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && bit_cnt != 4'd8) |=> $stable(addr4b_o));

  // R10
  miso_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csb_s && $past(csb_s)) |-> !miso);

  // R11
  wip_firmware_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |=> $stable(status_o[0]));
endmodule

bind spi_status_emu spi_status_emu_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .csb_s    (csb_s),
  .cs_rise  (cs_rise),
  .pending  (pending),
  .bit_cnt  (bit_cnt),
  .miso     (miso),
  .status_o (status_o),
  .addr4b_o (addr4b_o)
);

// File: tb/test_spi_status_emu.sv
module test_spi_status_emu;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, csb = 1'b1, mosi = 1'b0;
  logic miso;
  logic fw_wr = 1'b0;
  logic [23:0] fw_wdata = '0;
  logic [23:0] status_o;
  logic addr4b_o;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spi_status_emu i_spi_status_emu (
    .clk(clk), .rst_n(rst_n), .sck(sck), .csb(csb), .mosi(mosi), .miso(miso),
    .fw_wr(fw_wr), .fw_wdata(fw_wdata), .status_o(status_o), .addr4b_o(addr4b_o));

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [7:0] op, input int nbits, input int rdbits,
                       output logic [31:0] rd);
    rd = '0;
    csb = 1'b0;
    wait_clk(H);
    for (int i = 0; i < nbits + rdbits; i++) begin
      mosi = (i < 8) ? op[7-i] : 1'b0;
      wait_clk(H);
      if (i >= nbits) rd = {rd[30:0], miso};
      sck = 1'b1;
      wait_clk(H);
      sck = 1'b0;
    end
    wait_clk(H);
    csb = 1'b1;
    wait_clk(H);
  endtask

  task automatic fw_write(input logic [23:0] v);
    fw_wdata = v;
    fw_wr = 1'b1;
    wait_clk(1);
    fw_wr = 1'b0;
    wait_clk(2);
  endtask

  task automatic t_reset;
    chk("R10 status after reset", status_o, 0);
    chk("R10 addr4b after reset", addr4b_o, 0);
    chk("R10 miso idle", miso, 0);
  endtask

  task automatic t_wel;
    logic [31:0] rd;
    frame(8'h06, 8, 0, rd);
    chk("R1 WEL set", status_o, 24'h000002);
    frame(8'h05, 8, 8, rd);
    chk("R1 WEL over SPI", rd, 32'h02);
    frame(8'h04, 8, 0, rd);
    chk("R2 WEL cleared", status_o, 0);
  endtask

  task automatic t_mode;
    logic [31:0] rd;
    frame(8'hB7, 8, 0, rd);
    chk("R3 enter 4-byte", addr4b_o, 1);
    frame(8'hE9, 8, 0, rd);
    chk("R3 exit 4-byte", addr4b_o, 0);
  endtask

  task automatic t_staged_read;
    logic [31:0] rd;
    fw_write(24'h5A55AA);
    wait_clk(20);
    chk("R6 staged not yet live", status_o, 0);
    frame(8'h00, 8, 0, rd);
    chk("R6 staged live after frame", status_o, 24'h5A55AA);
    frame(8'h05, 8, 8, rd);
    chk("R4 byte0", rd, 32'hAA);
    frame(8'h35, 8, 8, rd);
    chk("R4 byte1", rd, 32'h55);
    frame(8'h15, 8, 8, rd);
    chk("R4 byte2", rd, 32'h5A);
    frame(8'h35, 8, 24, rd);
    chk("R5 repeat byte1", rd, 32'h555555);
    frame(8'h15, 8, 16, rd);
    chk("R5 repeat byte2", rd, 32'h5A5A);
  endtask

  task automatic t_unknown;
    logic [31:0] rd;
    frame(8'h9F, 8, 16, rd);
    chk("R8 unknown miso low", rd, 0);
    chk("R8 unknown no state change", status_o, 24'h5A55AA);
  endtask

  task automatic t_partial;
    logic [31:0] rd;
    frame(8'h04, 8, 0, rd);
    chk("R2 WEL cleared in loaded word", status_o, 24'h5A55A8);
    frame(8'h06, 7, 0, rd);
    chk("R7 7-bit WREN ignored", status_o, 24'h5A55A8);
    frame(8'h06, 9, 0, rd);
    chk("R7 9-bit WREN ignored", status_o, 24'h5A55A8);
    frame(8'hB7, 9, 0, rd);
    chk("R7 9-bit enter-4B ignored", addr4b_o, 0);
    frame(8'hB7, 7, 0, rd);
    chk("R7 7-bit enter-4B ignored", addr4b_o, 0);
  endtask

  task automatic t_priority;
    logic [31:0] rd;
    fw_write(24'h000000);
    frame(8'h06, 8, 0, rd);
    chk("R9 WREN over staged", status_o, 24'h000002);
    fw_write(24'hFFFFFF);
    frame(8'h04, 8, 0, rd);
    chk("R9 WRDI over staged", status_o, 24'hFFFFFD);
  endtask

  task automatic t_wip;
    logic [31:0] rd;
    fw_write(24'h000001);
    frame(8'h00, 8, 0, rd);
    chk("R11 WIP from firmware", status_o, 24'h000001);
    frame(8'h06, 8, 0, rd);
    frame(8'h04, 8, 0, rd);
    chk("R11 WIP kept by opcodes", status_o, 24'h000001);
    frame(8'h05, 8, 8, rd);
    chk("R11 WIP over SPI", rd, 32'h01);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_wel();
    t_mode();
    t_staged_read();
    t_unknown();
    t_partial();
    t_priority();
    t_wip();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule